// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on a single output line. A host loads a byte into a holding register and then clears the `empty_flag`. On the next baud tick the idle transmitter moves the byte into its shift register and starts the frame.

Because the holding register is separate from the shift register, the host can stage the next byte while the current frame is still going out. The transmitter looks at `empty_flag` once per frame, on the tick that starts the stop slot. If the flag is clear at that tick, the next frame follows the last stop bit with no gap. If it is set, the transmitter raises the end flag and the line returns to mark.

Each frame carries 7 or 8 data bits. An optional extra bit after the data is either parity or a multiprocessor marker, and the frame ends with one or two stop bits. Bit timing comes from an external baud tick. Each interrupt request is a level output: its flag ANDed with its enable.

Top module: `async_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1 and both `empty_flag` and `end_flag` read 1, and `txd` stays 1 whenever no frame is active.
- R2: A frame starts with one 0 bit, followed by the data bits least significant first: 8 bits when `cfg_seven`=0, or bits 0..6 when `cfg_seven`=1. Each bit lasts one baud tick interval.
- R3: With `cfg_par_en`=1 and `cfg_mp_en`=0, one bit follows the data. It is the XOR of the data bits actually sent, inverted when `cfg_par_odd`=1.
- R4: With `cfg_mp_en`=1, the bit after the data equals `cfg_mp_bit`, whatever the parity settings are. With both enables 0, no extra bit is sent.
- R5: The frame ends with 1 stop bit at 1 when `cfg_two_stop`=0, and with 2 stop bits when it is 1.
- R6: When the line is idle and a baud tick arrives while `empty_flag`=0, the held byte moves to the shift register. `empty_flag` becomes 1 on that same clock edge, and the start bit begins.
- R7: A pulse on `wr_data` stores `wdata` and clears `end_flag`. `empty_flag` is cleared only by `clr_empty`.
- R8: If `empty_flag` is 0 on the tick that begins the first stop bit, the held byte is loaded on that tick. Its start bit then follows the final stop bit with no idle bit between the frames.
- R9: If `empty_flag` is 1 on the tick that begins the first stop bit, `end_flag` becomes 1. After the stop bits the line stays at 1.
- R10: `irq_empty` equals `empty_flag` AND `ie_empty`, and `irq_end` equals `end_flag` AND `ie_end`, at all times.
- R11: The frame format inputs are captured when a byte is loaded into the shift register. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_data | input | 1 | Store `wdata` in the holding register |
| wdata | input | 8 | Byte to transmit |
| clr_empty | input | 1 | Clear the data-empty flag |
| cfg_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_mp_en | input | 1 | Append the multiprocessor bit instead of parity |
| cfg_mp_bit | input | 1 | Value of the multiprocessor bit |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| ie_empty | input | 1 | Enable for the data-empty request |
| ie_end | input | 1 | Enable for the transmit-end request |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding register is free |
| end_flag | output | 1 | Transmission finished, line at mark |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
A wrong bit counter or a wrong latched format shows up within one frame as a wrong bit or a wrong frame length on `txd`. A serial decoder in the bench catches it at the end of the frame. A chain flag that is lost or set by mistake changes the number of idle bits between two frames, so it shows one bit interval after the stop bits. A flag that is mishandled at the stop sample shows on `end_flag`, on `empty_flag` or on the interrupt outputs within one bit interval.

// File: rtl/async_tx_dbuf.sv
module async_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_empty,
  input  logic              cfg_seven,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_mp_en,
  input  logic              cfg_mp_bit,
  input  logic              cfg_two_stop,
  input  logic              ie_empty,
  input  logic              ie_end,
  output logic              txd,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_empty,
  output logic              irq_end
);

  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_FULL  = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(DATA_W - 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_EXTRA, S_STOP} st_t;

  st_t              st;
  logic [DATA_W-1:0] hold_q, shift_q;
  logic [CW-1:0]    cnt_q;
  logic             empty_q, end_q, chain_q, second_q;
  logic             short_q, extra_q, extra_bit_q, two_q;

  logic [DATA_W-1:0] masked;
  logic              extra_bit_nx, last_data, stop_entry, load_now;

  assign masked       = cfg_seven ? {1'b0, hold_q[DATA_W-2:0]} : hold_q;
  assign extra_bit_nx = cfg_mp_en ? cfg_mp_bit : (^masked) ^ cfg_par_odd;
  assign last_data    = cnt_q == (short_q ? LAST_SHORT : LAST_FULL);
  assign stop_entry   = baud_tick &&
                        ((st == S_DATA && last_data && !extra_q) || st == S_EXTRA);
  assign load_now     = !empty_q && ((baud_tick && st == S_IDLE) || stop_entry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      hold_q      <= '0;
      shift_q     <= '0;
      cnt_q       <= '0;
      empty_q     <= 1'b1;
      end_q       <= 1'b1;
      chain_q     <= 1'b0;
      second_q    <= 1'b0;
      short_q     <= 1'b0;
      extra_q     <= 1'b0;
      extra_bit_q <= 1'b0;
      two_q       <= 1'b0;
    end else begin
      if (clr_empty) empty_q <= 1'b0;
      if (wr_data)   hold_q  <= wdata;

      if (baud_tick) begin
        unique case (st)
          S_IDLE:  if (!empty_q) st <= S_START;
          S_START: begin
            st    <= S_DATA;
            cnt_q <= '0;
          end
          S_DATA: begin
            shift_q <= shift_q >> 1;
            cnt_q   <= cnt_q + 1'b1;
            if (last_data) begin
              st       <= extra_q ? S_EXTRA : S_STOP;
              second_q <= two_q;
            end
          end
          S_EXTRA: begin
            st       <= S_STOP;
            second_q <= two_q;
          end
          S_STOP: begin
            if (second_q)     second_q <= 1'b0;
            else if (chain_q) begin
              st      <= S_START;
              chain_q <= 1'b0;
            end else          st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end

      if (stop_entry) begin
        chain_q <= !empty_q;
        if (empty_q) end_q <= 1'b1;
      end
      if (wr_data) end_q <= 1'b0;

      if (load_now) begin
        shift_q     <= hold_q;
        empty_q     <= 1'b1;
        short_q     <= cfg_seven;
        extra_q     <= cfg_par_en | cfg_mp_en;
        extra_bit_q <= extra_bit_nx;
        two_q       <= cfg_two_stop;
      end
    end
  end

  always_comb begin
    unique case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = shift_q[0];
      S_EXTRA: txd = extra_bit_q;
      default: txd = 1'b1;
    endcase
  end

  assign empty_flag = empty_q;
  assign end_flag   = end_q;
  assign irq_empty  = empty_q & ie_empty;
  assign irq_end    = end_q & ie_end;

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_START |-> !txd);

  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_STOP |-> txd);

  p_load_sets_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && st == S_IDLE && !empty_q) |=> (empty_q && st == S_START));

  p_write_clears_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !end_q);

  p_chain_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && st == S_STOP && !second_q && chain_q) |=> st == S_START);

  p_end_at_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_q) |-> (st == S_STOP && !chain_q));

endmodule

// File: tb/async_tx_dbuf_test.sv
module async_tx_dbuf_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic wr_data = 0, clr_empty = 0;
  logic [7:0] wdata = 0;
  logic cfg_seven = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_mp_en = 0;
  logic cfg_mp_bit = 0, cfg_two_stop = 0, ie_empty = 0, ie_end = 0;
  logic txd, empty_flag, end_flag, irq_empty, irq_end;
  logic baud_tick;
  int tcnt = 0;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;
  assign baud_tick = (tcnt == 3);

  async_tx_dbuf uut (.*);

  logic [15:0] qv[$];
  int          qn[$];
  bit          qc[$];

  bit          busy = 0;
  int          gap = 0, idx = 0, cur_n = 0;
  logic [15:0] got = 0, cur_v = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (tcnt == 0 && rst_n) begin
      if (!busy) begin
        if (txd == 1'b0) begin
          if (qv.size() == 0) check(0, "R1 unexpected frame", 0, 1);
          else begin
            cur_v = qv.pop_front();
            cur_n = qn.pop_front();
            if (qc.pop_front()) check(gap == 0, "R8 chained gap", gap, 0);
            else                check(gap >= 1, "R9 idle before frame", gap, 1);
            got = 16'h0;
            idx = 1;
            busy = 1;
          end
        end else gap++;
      end else begin
        got[idx] = txd;
        idx++;
        if (idx == cur_n) begin
          check(got == cur_v, "R2 R3 R4 R5 R11 frame bits", got, cur_v);
          busy = 0;
          gap = 0;
        end
      end
    end
    tcnt = (tcnt + 1) % 4;
  end

  task automatic expect_frame(input logic [7:0] d, input bit sev, input bit pe,
                              input bit odd, input bit me, input bit mb,
                              input bit two, input bit chained);
    logic [15:0] v = 16'h0;
    int n = 1;
    int nb = sev ? 7 : 8;
    bit p = 0;
    for (int i = 0; i < nb; i++) begin
      v[n] = d[i];
      p ^= d[i];
      n++;
    end
    if (me)      begin v[n] = mb;      n++; end
    else if (pe) begin v[n] = p ^ odd; n++; end
    v[n] = 1; n++;
    if (two) begin v[n] = 1; n++; end
    qv.push_back(v);
    qn.push_back(n);
    qc.push_back(chained);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr_data = 1; wdata = d;
    @(negedge clk); wr_data = 0;
  endtask

  task automatic host_clear;
    @(negedge clk); clr_empty = 1;
    @(negedge clk); clr_empty = 0;
  endtask

  task automatic wait_quiet;
    repeat (4 * 30) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "R1 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(txd == 1 && empty_flag == 1 && end_flag == 1, "R1 reset state",
          {txd, empty_flag, end_flag}, 3'b111);
    rst_n = 1;
    repeat (12) @(negedge clk);
    check(txd == 1, "R1 idle mark", txd, 1);

    for (int c = 0; c < 32; c++) begin
      logic [7:0] d0 = 8'(c * 37 + 5);
      logic [7:0] d1 = 8'(c * 91 + 170);
      logic [7:0] d2 = 8'(~(c * 13));
      cfg_seven = c[0]; cfg_par_en = c[1]; cfg_par_odd = c[2];
      cfg_mp_en = c[3]; cfg_two_stop = c[4]; cfg_mp_bit = c[1] ^ c[4];
      ie_empty = c[0] ^ c[2]; ie_end = c[1] ^ c[3];

      host_write(d0);
      check(end_flag == 0, "R7 write clears end", end_flag, 0);
      check(empty_flag == 1, "R7 write keeps empty", empty_flag, 1);
      expect_frame(d0, c[0], c[1], c[2], c[3], cfg_mp_bit, c[4], 0);
      host_clear;
      check(irq_empty == (empty_flag & ie_empty), "R10 irq_empty low", irq_empty, empty_flag & ie_empty);
      @(posedge empty_flag);
      @(negedge clk);
      check(txd == 0, "R6 start at load", txd, 0);
      check(irq_empty == ie_empty, "R10 irq_empty set", irq_empty, ie_empty);

      host_write(d1);
      expect_frame(d1, c[0], c[1], c[2], c[3], cfg_mp_bit, c[4], 1);
      host_clear;
      @(posedge empty_flag);
      host_write(d2);
      expect_frame(d2, c[0], c[1], c[2], c[3], cfg_mp_bit, c[4], 1);
      host_clear;
      @(posedge empty_flag);
      check(end_flag == 0, "R8 no end while chaining", end_flag, 0);
      wait (end_flag == 1);
      @(negedge clk);
      check(irq_end == ie_end, "R10 irq_end", irq_end, ie_end);
      wait_quiet;
      check(txd == 1 && end_flag == 1, "R9 mark after end", {txd, end_flag}, 2'b11);
    end

    cfg_seven = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_mp_en = 0; cfg_two_stop = 0;
    host_write(8'hC3);
    expect_frame(8'hC3, 0, 1, 0, 0, 0, 0, 0);
    host_clear;
    @(posedge empty_flag);
    @(negedge clk);
    cfg_seven = 1; cfg_par_en = 0; cfg_mp_en = 1; cfg_mp_bit = 1; cfg_two_stop = 1;
    host_write(8'h5A);
    wait (end_flag == 1);
    check(empty_flag == 1, "R9 not chained without clear", empty_flag, 1);
    cfg_seven = 0; cfg_par_en = 1; cfg_mp_en = 0; cfg_two_stop = 0;
    wait_quiet;
    check(end_flag == 1 && txd == 1, "R9 end held", {end_flag, txd}, 2'b11);
    expect_frame(8'h5A, 0, 1, 0, 0, 0, 0, 0);
    host_clear;
    wait (end_flag == 1);
    wait_quiet;

    check(qv.size() == 0, "R2 all frames seen", qv.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule